// File: doc/BRIEF.md
# VID Slew-Rate Ramp Controller

This block owns the digital reference code that a core-voltage regulator's DAC turns into its set point. A command supplies an 8-bit target code and one of three transition styles. In the two controlled styles the reference walks one code at a time toward the target. A fractional credit accumulator fed by a 1 µs tick paces those steps. In the uncontrolled style the reference does not walk. It follows a measured output code down as the load drains the output, and a no-sink flag tells the power stage not to pull current through the low-side switch.

Codes map to voltage as follows: 00h is shutdown (0 V), 01h is 0.500 V, and each further code adds 10 mV, up to 3.040 V at FFh. A signed offset in code steps is added to the commanded code. The result is floored at 01h and capped at a programmed maximum. Target, offset, maximum and style are all captured on the start strobe. The FSM has four states: `ST_IDLE`, `ST_RAMP_UP`, `ST_RAMP_DN` and `ST_DECAY`. The start strobe leaves any state for `ST_IDLE` (target equals reference), `ST_RAMP_UP` (target above), `ST_DECAY` (target below in decay style) or `ST_RAMP_DN` (target below otherwise). A ramp state returns to `ST_IDLE` on the step that lands on the target. `ST_DECAY` returns to `ST_IDLE` once the measured code is at or below the target.

The tick must be no more frequent than one pulse every two clocks, so that credits never pile up faster than one step per clock drains them.

Top module: `vid_ramp_ctrl`

## Requirements
- R1: After reset the reference is 00h, busy is low, settled is high and no-sink is low. While settled and no start arrives, the reference does not change, even when ticks arrive.
- R2: A start strobe raises busy and drops settled in the next cycle when the computed target differs from the reference. When the target equals the reference, the block stays settled and not busy.
- R3: Style 2'b00 (fast) moves the reference toward the target at 5 codes per 4 ticks: after T ticks it has moved floor(5T/4) codes, capped at the target, and never more than one code per clock.
- R4: Style 2'b01 (slow) moves 5 codes per 16 ticks: floor(5T/16) codes after T ticks. Style 2'b11 behaves as slow.
- R5: The target is the commanded code plus the two's-complement 8-bit offset. A commanded code of 00h gives target 00h whatever the offset.
- R6: For a nonzero commanded code, a sum below 01h is floored to 01h, and a sum above the maximum is clamped to the maximum.
- R7: Steps pass directly between 00h and 01h in both directions.
- R8: A start during a ramp leaves the reference where it is in that cycle and continues toward the new target from there. Settled rises in the cycle the reference equals the target.
- R9: Style 2'b10 (decay) with a target below the reference holds no-sink and busy high. The reference follows the measured code only downward, one cycle after it is sampled. Once the measured code is at or below the target, the reference takes the target value, settled rises and no-sink falls.
- R10: Style 2'b10 with a target above the reference ramps up at the fast rate with no-sink low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle command strobe |
| mode_i | input | 2 | Transition style: 00 fast, 01 slow, 10 decay, 11 slow |
| cmd_vid_i | input | 8 | Commanded target code |
| offset_i | input | 8 | Signed offset in code steps |
| vmax_i | input | 8 | Highest allowed target code |
| tick_us_i | input | 1 | 1 µs time-base pulse |
| meas_vid_i | input | 8 | Measured output expressed as a code |
| ref_vid_o | output | 8 | Present reference code |
| busy_o | output | 1 | Transition in progress |
| settled_o | output | 1 | Reference has reached the target |
| no_sink_o | output | 1 | Low-side sinking forbidden |

## Verification
The bench builds the block with its default parameters: 8-bit codes and step ratios of 5/4 and 5/16. It spaces ticks eight clocks apart, so every credit drains before the next tick. At that spacing the code moved after T ticks is an exact floor of a ratio, and partial counts separate the two rates. The 8-bit width puts 00h, 01h and the cap within a few dozen ticks. Offsets of both signs reach the floor and the cap, and the decay run drives the measured code both above and below the reference.

// File: rtl/vid_ramp_pkg.sv
package vid_ramp_pkg;

    typedef enum logic [1:0] {
        MODE_FAST  = 2'b00,
        MODE_SLOW  = 2'b01,
        MODE_DECAY = 2'b10,
        MODE_RSVD  = 2'b11
    } ramp_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'b00,
        ST_RAMP_UP = 2'b01,
        ST_RAMP_DN = 2'b10,
        ST_DECAY   = 2'b11
    } ramp_state_e;

endpackage

// File: rtl/vid_target_calc.sv
// Offset addition, nonzero floor and upper clamp for the commanded code.
module vid_target_calc #(
    parameter int VID_W = 8
) (
    input  logic [VID_W-1:0] cmd_i,
    input  logic [VID_W-1:0] offset_i,
    input  logic [VID_W-1:0] vmax_i,
    output logic [VID_W-1:0] tgt_o
);
    localparam int SW = VID_W + 2;

    logic signed [SW-1:0] sum_s;
    logic signed [SW-1:0] floored_s;
    logic signed [SW-1:0] max_s;

    always_comb begin
        sum_s     = $signed({2'b00, cmd_i}) + $signed({{2{offset_i[VID_W-1]}}, offset_i});
        max_s     = $signed({2'b00, vmax_i});
        floored_s = (sum_s < $signed(SW'(1))) ? $signed(SW'(1)) : sum_s;
        if (cmd_i == '0)
            tgt_o = '0;
        else if (floored_s > max_s)
            tgt_o = vmax_i;
        else
            tgt_o = floored_s[VID_W-1:0];
    end
endmodule

// File: rtl/vid_step_gen.sv
// Fractional step credit: each tick adds NUM, each taken step removes DEN.
module vid_step_gen #(
    parameter int FAST_NUM = 5,
    parameter int FAST_DEN = 4,
    parameter int SLOW_NUM = 5,
    parameter int SLOW_DEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic tick_i,
    input  logic fast_i,
    input  logic take_i,
    output logic credit_o
);
    localparam int MAX_NUM = (FAST_NUM > SLOW_NUM) ? FAST_NUM : SLOW_NUM;
    localparam int MAX_DEN = (FAST_DEN > SLOW_DEN) ? FAST_DEN : SLOW_DEN;
    localparam int ACC_W   = $clog2(2 * (MAX_NUM + MAX_DEN)) + 1;

    localparam logic [ACC_W-1:0] F_NUM = ACC_W'(FAST_NUM);
    localparam logic [ACC_W-1:0] F_DEN = ACC_W'(FAST_DEN);
    localparam logic [ACC_W-1:0] S_NUM = ACC_W'(SLOW_NUM);
    localparam logic [ACC_W-1:0] S_DEN = ACC_W'(SLOW_DEN);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] num;
    logic [ACC_W-1:0] den;
    logic [ACC_W-1:0] add;
    logic [ACC_W-1:0] sub;

    always_comb begin
        num      = fast_i ? F_NUM : S_NUM;
        den      = fast_i ? F_DEN : S_DEN;
        add      = tick_i ? num : '0;
        sub      = take_i ? den : '0;
        credit_o = (acc_q >= den);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            acc_q <= '0;
        else if (clear_i)
            acc_q <= '0;
        else
            acc_q <= acc_q + add - sub;
    end
endmodule

// File: rtl/vid_ramp_fsm.sv
module vid_ramp_fsm
    import vid_ramp_pkg::*;
#(
    parameter int VID_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  ramp_mode_e       mode_i,
    input  logic [VID_W-1:0] tgt_i,
    input  logic [VID_W-1:0] meas_i,
    input  logic             credit_i,
    output logic [VID_W-1:0] ref_o,
    output logic [VID_W-1:0] tgt_o,
    output logic             fast_o,
    output logic             take_o,
    output logic             clear_o,
    output logic             busy_o,
    output logic             settled_o,
    output logic             no_sink_o
);
    ramp_state_e      state_q, state_n;
    logic [VID_W-1:0] ref_q, ref_n;
    logic [VID_W-1:0] tgt_q, tgt_n;
    logic             fast_q, fast_n;

    // State and datapath register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ref_q   <= '0;
            tgt_q   <= '0;
            fast_q  <= 1'b1;
        end else begin
            state_q <= state_n;
            ref_q   <= ref_n;
            tgt_q   <= tgt_n;
            fast_q  <= fast_n;
        end
    end

    // Next state
    always_comb begin
        state_n = state_q;
        ref_n   = ref_q;
        tgt_n   = tgt_q;
        fast_n  = fast_q;
        take_o  = 1'b0;
        if (start_i) begin
            tgt_n = tgt_i;
            if (tgt_i == ref_q) begin
                state_n = ST_IDLE;
            end else if (tgt_i > ref_q) begin
                state_n = ST_RAMP_UP;
                fast_n  = (mode_i == MODE_FAST) || (mode_i == MODE_DECAY);
            end else if (mode_i == MODE_DECAY) begin
                state_n = ST_DECAY;
            end else begin
                state_n = ST_RAMP_DN;
                fast_n  = (mode_i == MODE_FAST);
            end
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_RAMP_UP: begin
                    if (credit_i) begin
                        take_o = 1'b1;
                        ref_n  = ref_q + 1'b1;
                        if (ref_q + 1'b1 == tgt_q)
                            state_n = ST_IDLE;
                    end
                end
                ST_RAMP_DN: begin
                    if (credit_i) begin
                        take_o = 1'b1;
                        ref_n  = ref_q - 1'b1;
                        if (ref_q - 1'b1 == tgt_q)
                            state_n = ST_IDLE;
                    end
                end
                ST_DECAY: begin
                    if (meas_i <= tgt_q) begin
                        ref_n   = tgt_q;
                        state_n = ST_IDLE;
                    end else if (meas_i < ref_q) begin
                        ref_n = meas_i;
                    end
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy_o    = 1'b1;
        settled_o = 1'b0;
        no_sink_o = 1'b0;
        clear_o   = start_i;
        unique case (state_q)
            ST_IDLE: begin
                busy_o    = 1'b0;
                settled_o = 1'b1;
                clear_o   = 1'b1;
            end
            ST_RAMP_UP, ST_RAMP_DN: ;
            ST_DECAY: begin
                no_sink_o = 1'b1;
                clear_o   = 1'b1;
            end
        endcase
        ref_o  = ref_q;
        tgt_o  = tgt_q;
        fast_o = fast_q;
    end
endmodule

// File: rtl/vid_ramp_ctrl.sv
module vid_ramp_ctrl
    import vid_ramp_pkg::*;
#(
    parameter int VID_W    = 8,
    parameter int FAST_NUM = 5,
    parameter int FAST_DEN = 4,
    parameter int SLOW_NUM = 5,
    parameter int SLOW_DEN = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [1:0]       mode_i,
    input  logic [VID_W-1:0] cmd_vid_i,
    input  logic [VID_W-1:0] offset_i,
    input  logic [VID_W-1:0] vmax_i,
    input  logic             tick_us_i,
    input  logic [VID_W-1:0] meas_vid_i,
    output logic [VID_W-1:0] ref_vid_o,
    output logic             busy_o,
    output logic             settled_o,
    output logic             no_sink_o
);
    logic [VID_W-1:0] tgt_calc;
    logic [VID_W-1:0] tgt_q;
    logic             credit;
    logic             take;
    logic             clear;
    logic             fast;

    vid_target_calc #(.VID_W(VID_W)) u_tgt (
        .cmd_i    (cmd_vid_i),
        .offset_i (offset_i),
        .vmax_i   (vmax_i),
        .tgt_o    (tgt_calc)
    );

    vid_step_gen #(
        .FAST_NUM (FAST_NUM),
        .FAST_DEN (FAST_DEN),
        .SLOW_NUM (SLOW_NUM),
        .SLOW_DEN (SLOW_DEN)
    ) u_step (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (clear),
        .tick_i   (tick_us_i),
        .fast_i   (fast),
        .take_i   (take),
        .credit_o (credit)
    );

    vid_ramp_fsm #(.VID_W(VID_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .mode_i    (ramp_mode_e'(mode_i)),
        .tgt_i     (tgt_calc),
        .meas_i    (meas_vid_i),
        .credit_i  (credit),
        .ref_o     (ref_vid_o),
        .tgt_o     (tgt_q),
        .fast_o    (fast),
        .take_o    (take),
        .clear_o   (clear),
        .busy_o    (busy_o),
        .settled_o (settled_o),
        .no_sink_o (no_sink_o)
    );
endmodule

// File: rtl/vid_ramp_chk.sv
module vid_ramp_chk #(
    parameter int VID_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [VID_W-1:0] ref_vid_o,
    input logic [VID_W-1:0] tgt_q,
    input logic             busy_o,
    input logic             settled_o,
    input logic             no_sink_o
);
    // R1: idle reference holds without a command
    a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (settled_o && !start_i) |=> $stable(ref_vid_o));

    // R3: controlled ramps move at most one code per clock
    a_r3_one_code_per_clk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !no_sink_o && !start_i) |=>
            ((ref_vid_o == $past(ref_vid_o)) ||
             (ref_vid_o == $past(ref_vid_o) + 1'b1) ||
             (ref_vid_o == $past(ref_vid_o) - 1'b1)));

    // R8: a command never makes the reference jump
    a_r8_start_no_jump: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> $stable(ref_vid_o));

    // R8: settled rises only with the reference on the target
    a_r8_settle_at_target: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(settled_o) |-> (ref_vid_o == tgt_q));

    // R9: decay only ever lowers the reference
    a_r9_decay_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        (no_sink_o && !start_i) |=> (ref_vid_o <= $past(ref_vid_o)));

    // R9: sinking is forbidden only while a transition is in progress
    a_r9_nosink_busy: assert property (@(posedge clk) disable iff (!rst_n)
        no_sink_o |-> busy_o);
endmodule

bind vid_ramp_ctrl vid_ramp_chk #(.VID_W(VID_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .ref_vid_o (ref_vid_o),
    .tgt_q     (tgt_q),
    .busy_o    (busy_o),
    .settled_o (settled_o),
    .no_sink_o (no_sink_o)
);

// File: tb/tb_vid_ramp_ctrl.sv
`timescale 1ns/1ps
module tb_vid_ramp_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [1:0] mode_i = 2'b00;
    logic [7:0] cmd_vid_i = 8'h00;
    logic [7:0] offset_i = 8'h00;
    logic [7:0] vmax_i = 8'hFF;
    logic       tick_us_i = 1'b0;
    logic [7:0] meas_vid_i = 8'h00;
    logic [7:0] ref_vid_o;
    logic       busy_o, settled_o, no_sink_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #4 clk = ~clk;

    vid_ramp_ctrl dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .cmd_vid_i(cmd_vid_i), .offset_i(offset_i), .vmax_i(vmax_i),
        .tick_us_i(tick_us_i), .meas_vid_i(meas_vid_i),
        .ref_vid_o(ref_vid_o), .busy_o(busy_o), .settled_o(settled_o),
        .no_sink_o(no_sink_o)
    );

    typedef struct {
        string      tag;
        logic [7:0] r;
        logic       b;
        logic       s;
        logic       n;
    } exp_t;

    exp_t exp_q[$];

    // Monitor: pops expectations and compares against the live outputs
    initial begin
        forever begin
            exp_t it;
            wait (exp_q.size() != 0);
            it = exp_q.pop_front();
            n_tests++;
            if (ref_vid_o !== it.r || busy_o !== it.b ||
                settled_o !== it.s || no_sink_o !== it.n) begin
                n_fail++;
                $display("FAIL %s: ref=%02h busy=%0b settled=%0b nosink=%0b expected ref=%02h busy=%0b settled=%0b nosink=%0b",
                         it.tag, ref_vid_o, busy_o, settled_o, no_sink_o,
                         it.r, it.b, it.s, it.n);
            end
        end
    end

    task automatic expect_out(string tag, logic [7:0] r, logic b, logic s, logic n);
        exp_q.push_back('{tag, r, b, s, n});
    endtask

    // Called at a negedge; returns one negedge later with the command taken
    task automatic go(logic [1:0] m, logic [7:0] c, logic [7:0] o, logic [7:0] mx);
        mode_i    = m;
        cmd_vid_i = c;
        offset_i  = o;
        vmax_i    = mx;
        start_i   = 1'b1;
        @(negedge clk);
        start_i   = 1'b0;
    endtask

    // Each tick is followed by eight clocks so every credit drains
    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            tick_us_i = 1'b1;
            @(negedge clk);
            tick_us_i = 1'b0;
            repeat (7) @(negedge clk);
        end
    endtask

    initial begin
        int cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: run did not finish, cycles=%0d expected < 150000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_out("R1 reset state", 8'h00, 0, 1, 0);

        // Fast ramp up from shutdown, crossing 00h->01h
        go(2'b00, 8'h14, 8'h00, 8'hFF);
        expect_out("R2 busy after start", 8'h00, 1, 0, 0);
        ticks(4);
        expect_out("R3 fast 4 ticks / R7 00->01", 8'h05, 1, 0, 0);
        ticks(4);
        expect_out("R3 fast 8 ticks", 8'h0A, 1, 0, 0);
        ticks(8);
        expect_out("R3 fast reaches target / R8 settled", 8'h14, 0, 1, 0);
        ticks(4);
        expect_out("R1 idle ignores ticks", 8'h14, 0, 1, 0);

        // Slow ramp down
        go(2'b01, 8'h0A, 8'h00, 8'hFF);
        ticks(16);
        expect_out("R4 slow 16 ticks", 8'h0F, 1, 0, 0);
        ticks(16);
        expect_out("R4 slow reaches target", 8'h0A, 0, 1, 0);

        // Positive and negative offsets
        go(2'b00, 8'h0A, 8'h03, 8'hFF);
        ticks(3);
        expect_out("R5 positive offset", 8'h0D, 0, 1, 0);
        go(2'b00, 8'h0A, 8'hFB, 8'hFF);
        ticks(7);
        expect_out("R5 negative offset", 8'h05, 0, 1, 0);

        // Cap at maximum
        go(2'b00, 8'h30, 8'h00, 8'h0C);
        ticks(6);
        expect_out("R6 capped at max", 8'h0C, 0, 1, 0);
        ticks(2);
        expect_out("R6 stays at cap", 8'h0C, 0, 1, 0);

        // Floor at 01h
        go(2'b00, 8'h02, 8'hF6, 8'hFF);
        ticks(9);
        expect_out("R6 floored to 01h", 8'h01, 0, 1, 0);

        // 01h -> 00h with an offset that must be ignored for code 00h
        go(2'b00, 8'h00, 8'h03, 8'hFF);
        ticks(1);
        expect_out("R7 01->00 / R5 zero ignores offset", 8'h00, 0, 1, 0);

        // Retarget mid-ramp
        go(2'b00, 8'h14, 8'h00, 8'hFF);
        ticks(4);
        expect_out("R8 before retarget", 8'h05, 1, 0, 0);
        go(2'b00, 8'h02, 8'h00, 8'hFF);
        expect_out("R8 retarget no jump", 8'h05, 1, 0, 0);
        ticks(3);
        expect_out("R8 retarget reaches new target", 8'h02, 0, 1, 0);

        // Target equal to reference
        go(2'b00, 8'h02, 8'h00, 8'hFF);
        expect_out("R2 equal target stays settled", 8'h02, 0, 1, 0);

        // Decay
        go(2'b00, 8'h1E, 8'h00, 8'hFF);
        ticks(23);
        expect_out("R3 ramp to 1Eh", 8'h1E, 0, 1, 0);
        meas_vid_i = 8'h1E;
        go(2'b10, 8'h0A, 8'h00, 8'hFF);
        expect_out("R9 decay start no-sink", 8'h1E, 1, 0, 1);
        meas_vid_i = 8'h19;
        @(negedge clk);
        expect_out("R9 follows measured down", 8'h19, 1, 0, 1);
        meas_vid_i = 8'h1B;
        @(negedge clk);
        expect_out("R9 ignores measured rise", 8'h19, 1, 0, 1);
        ticks(2);
        expect_out("R9 ticks do not move decay", 8'h19, 1, 0, 1);
        meas_vid_i = 8'h09;
        @(negedge clk);
        expect_out("R9 settles at target, sink released", 8'h0A, 0, 1, 0);

        // Decay upward
        go(2'b10, 8'h0F, 8'h00, 8'hFF);
        expect_out("R10 decay upward no-sink low", 8'h0A, 1, 0, 0);
        ticks(4);
        expect_out("R10 decay upward fast rate", 8'h0F, 0, 1, 0);

        // Reserved style behaves as slow
        go(2'b11, 8'h14, 8'h00, 8'hFF);
        ticks(15);
        expect_out("R4 style 11 slow partial", 8'h13, 1, 0, 0);
        ticks(1);
        expect_out("R4 style 11 slow done", 8'h14, 0, 1, 0);

        wait (exp_q.size() == 0);
        @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule